// File: doc/BRIEF.md
# Programmable Interrupt Priority Resolver

This block picks one interrupt request to acknowledge each time the processor reaches a sampling point. It has a vector of maskable peripheral request lines. Each line has its own 3-bit priority level that software can set. It also has a set of special inputs whose rank is fixed in hardware: reset, software interrupt, non-maskable, debug, watchdog/oscillation-stop, single-step and address-match. The requests seen at a sampling point are compared, and one cycle later the block raises a one-cycle acknowledge with the winner's index and level.

When a request is acknowledged, the block pushes the processor's current priority level and register-bank select onto a small context stack. It then loads the winner's level and the bank chosen for interrupt entry. A return-from-interrupt pulse pops the saved pair and restores it. A push onto a full stack sets a sticky error flag.

Top module: `irq_prio_resolver`

## Requirements
- R1: The block arbitrates only in a cycle where `sample_en` is high. If it finds a winner, `ack` is high for exactly the next cycle. With no sample, or with a sample that finds no request that can be accepted, `ack` stays low. A request raised between samples waits for the next sample.
- R2: A maskable request `irq_req[i]` can be accepted only when all of these hold: its level field (bits `3i+2:3i` of `irq_lvl`) is nonzero, that level is strictly greater than `cur_ipl`, and `int_en` is 1.
- R3: Among the maskable requests that can be accepted, the one with the highest level wins. If several share that level, the lowest index wins. `ack_id` gives that index (0 to 7) and `ack_lvl` gives its level.
- R4: The fixed order, from highest to lowest, is: reset (id 8), software (id 9), NMI (id 10), debug (id 11), watchdog (id 12), all maskable sources (ids 0 to 7), single-step (id 13), address-match (id 14).
- R5: The special inputs and the software request ignore `int_en` and `cur_ipl`. A software acknowledge reports the current `cur_ipl` as `ack_lvl` and leaves `cur_ipl` unchanged. Every other special input reports level 7.
- R6: On an acknowledge, the previous `{cur_ipl, cur_bank}` pair is pushed onto the stack. In the cycle `ack` is high, `cur_ipl` equals `ack_lvl` and `cur_bank` equals the `entry_bank` value that was present at the sample.
- R7: A `ret_pulse` pops the newest saved pair into `cur_ipl`/`cur_bank` one cycle later. A pulse on an empty stack is ignored. A pulse in the same cycle as a sample that produces an acknowledge is also ignored.
- R8: A push onto a full stack (4 entries) drops the entry and sets `stk_ovf`. The priority level still updates. `stk_ovf` stays high until `rst_n` is asserted.
- R9: After `rst_n` is asserted (active low): `ack`, `cur_ipl`, `cur_bank` and `stk_ovf` are 0 and the stack is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_en | input | 1 | Marks a sampling point (one cycle) |
| irq_req | input | N_SRC | Maskable request lines |
| irq_lvl | input | N_SRC*LVL_W | Per-source priority levels, source i at bits LVL_W*i upward |
| int_en | input | 1 | Global maskable interrupt enable |
| rst_req | input | 1 | Reset interrupt request |
| swi_req | input | 1 | Software interrupt request |
| nmi_req | input | 1 | Non-maskable request |
| dbg_req | input | 1 | Debug request |
| wdt_req | input | 1 | Watchdog / oscillation-stop request |
| step_req | input | 1 | Single-step request |
| amatch_req | input | 1 | Address-match request |
| ret_pulse | input | 1 | Return-from-interrupt pulse |
| entry_bank | input | BANK_W | Register-bank select applied on entry |
| ack | output | 1 | One-cycle acknowledge strobe |
| ack_id | output | ID_W | Winning source index |
| ack_lvl | output | LVL_W | Winning level |
| cur_ipl | output | LVL_W | Current processor priority level |
| cur_bank | output | BANK_W | Current register-bank select |
| stk_ovf | output | 1 | Sticky context-stack overflow |

## Verification
The assertions check the following on every cycle:
- An acknowledge always follows a sample.
- A sample with no pending line gives no acknowledge.
- A maskable winner always beat the earlier priority level while enables were set.
- A reset request always wins.
- The priority level equals the acknowledged level.
- The overflow flag never clears by itself.

Only the bench scenarios can show the rest:
- Tie-breaks among equal levels.
- The full fixed order of the special tier.
- Context restore order across nested entries.
- Ignored returns.
- The fact that the dropped overflow entry is lost.

// File: rtl/irqpr_pkg.sv
package irqpr_pkg;
   // Offsets of the special sources inside the special request vector.
   // The order of these constants is also their id order after N_SRC.
   localparam int SP_RESET = 0;
   localparam int SP_SWI   = 1;
   localparam int SP_NMI   = 2;
   localparam int SP_DEBUG = 3;
   localparam int SP_WDT   = 4;
   localparam int SP_STEP  = 5;
   localparam int SP_ADDR  = 6;
   localparam int SP_COUNT = 7;

   function automatic int special_id(input int n_src, input int sp);
      return n_src + sp;
   endfunction
endpackage

// File: rtl/irqpr_mask_arb.sv
module irqpr_mask_arb #(
   parameter int N_SRC = 8,
   parameter int LVL_W = 3,
   localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
   input  logic [N_SRC-1:0]       req,
   input  logic [N_SRC*LVL_W-1:0] lvl_cfg,
   input  logic                   int_en,
   input  logic [LVL_W-1:0]       cur_ipl,
   output logic                   hit,
   output logic [IDX_W-1:0]       win_idx,
   output logic [LVL_W-1:0]       win_lvl
);
   logic [LVL_W-1:0] lvl_a [N_SRC];
   logic [N_SRC-1:0] elig;

   for (genvar g = 0; g < N_SRC; g++) begin : g_src
      assign lvl_a[g] = lvl_cfg[g*LVL_W +: LVL_W];
      assign elig[g]  = int_en && req[g] && (lvl_a[g] != '0) && (lvl_a[g] > cur_ipl);
   end

   // Ascending scan with strict compare: the first source at the top level is kept.
   always_comb begin
      hit     = 1'b0;
      win_idx = '0;
      win_lvl = '0;
      for (int i = 0; i < N_SRC; i++) begin
         if (elig[i] && (!hit || (lvl_a[i] > win_lvl))) begin
            hit     = 1'b1;
            win_idx = IDX_W'(i);
            win_lvl = lvl_a[i];
         end
      end
   end
endmodule

// File: rtl/irqpr_tier_sel.sv
module irqpr_tier_sel
   import irqpr_pkg::*;
#(
   parameter int N_SRC = 8,
   parameter int LVL_W = 3,
   parameter int ID_W  = 4,
   localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1,
   localparam logic [LVL_W-1:0] TOP_LVL = {LVL_W{1'b1}}
) (
   input  logic [SP_COUNT-1:0] sp_vec,
   input  logic                mask_hit,
   input  logic [IDX_W-1:0]    mask_idx,
   input  logic [LVL_W-1:0]    mask_lvl,
   input  logic [LVL_W-1:0]    cur_ipl,
   output logic                valid,
   output logic [ID_W-1:0]     win_id,
   output logic [LVL_W-1:0]    win_lvl
);
   function automatic logic [ID_W-1:0] sid(input int sp);
      return ID_W'(special_id(N_SRC, sp));
   endfunction

   always_comb begin
      valid   = 1'b1;
      win_id  = '0;
      win_lvl = TOP_LVL;
      if (sp_vec[SP_RESET]) begin
         win_id = sid(SP_RESET);
      end else if (sp_vec[SP_SWI]) begin
         win_id  = sid(SP_SWI);
         win_lvl = cur_ipl;
      end else if (sp_vec[SP_NMI]) begin
         win_id = sid(SP_NMI);
      end else if (sp_vec[SP_DEBUG]) begin
         win_id = sid(SP_DEBUG);
      end else if (sp_vec[SP_WDT]) begin
         win_id = sid(SP_WDT);
      end else if (mask_hit) begin
         win_id  = ID_W'(mask_idx);
         win_lvl = mask_lvl;
      end else if (sp_vec[SP_STEP]) begin
         win_id = sid(SP_STEP);
      end else if (sp_vec[SP_ADDR]) begin
         win_id = sid(SP_ADDR);
      end else begin
         valid   = 1'b0;
         win_lvl = '0;
      end
   end
endmodule

// File: rtl/irqpr_ctx_stack.sv
module irqpr_ctx_stack #(
   parameter int DEPTH = 4,
   parameter int W     = 4,
   localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic         pop,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout,
   output logic         empty,
   output logic         ovf
);
   logic [W-1:0]     mem [DEPTH];
   logic [CNT_W-1:0] cnt;
   logic             full;
   logic [AW-1:0]    rd_ptr;

   assign full   = (cnt == CNT_W'(DEPTH));
   assign empty  = (cnt == '0);
   assign rd_ptr = AW'(cnt - 1'b1);
   assign dout   = empty ? '0 : mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
         ovf <= 1'b0;
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (push) begin
         if (full) begin
            ovf <= 1'b1;
         end else begin
            mem[AW'(cnt)] <= din;
            cnt           <= cnt + 1'b1;
         end
      end else if (pop && !empty) begin
         cnt <= cnt - 1'b1;
      end
   end
endmodule

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver
   import irqpr_pkg::*;
#(
   parameter int N_SRC     = 8,
   parameter int LVL_W     = 3,
   parameter int STK_DEPTH = 4,
   parameter int BANK_W    = 1,
   localparam int ID_W = $clog2(N_SRC + SP_COUNT)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   sample_en,
   input  logic [N_SRC-1:0]       irq_req,
   input  logic [N_SRC*LVL_W-1:0] irq_lvl,
   input  logic                   int_en,
   input  logic                   rst_req,
   input  logic                   swi_req,
   input  logic                   nmi_req,
   input  logic                   dbg_req,
   input  logic                   wdt_req,
   input  logic                   step_req,
   input  logic                   amatch_req,
   input  logic                   ret_pulse,
   input  logic [BANK_W-1:0]      entry_bank,
   output logic                   ack,
   output logic [ID_W-1:0]        ack_id,
   output logic [LVL_W-1:0]       ack_lvl,
   output logic [LVL_W-1:0]       cur_ipl,
   output logic [BANK_W-1:0]      cur_bank,
   output logic                   stk_ovf
);
   localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;
   localparam int CTX_W = LVL_W + BANK_W;

   if (N_SRC < 1 || LVL_W < 1 || STK_DEPTH < 2 || BANK_W < 1) begin : g_bad_cfg
      initial $error("irq_prio_resolver: illegal parameter set");
   end

   logic [SP_COUNT-1:0] sp_vec;
   logic                m_hit;
   logic [IDX_W-1:0]    m_idx;
   logic [LVL_W-1:0]    m_lvl;
   logic                w_valid;
   logic [ID_W-1:0]     w_id;
   logic [LVL_W-1:0]    w_lvl;
   logic                fire;
   logic                pop_ok;
   logic [CTX_W-1:0]    stk_dout;
   logic                stk_empty;
   logic                ack_q;
   logic [ID_W-1:0]     id_q;
   logic [LVL_W-1:0]    lvl_q;
   logic [LVL_W-1:0]    ipl_q;
   logic [BANK_W-1:0]   bank_q;

   assign sp_vec = {amatch_req, step_req, wdt_req, dbg_req, nmi_req, swi_req, rst_req};

   irqpr_mask_arb #(.N_SRC(N_SRC), .LVL_W(LVL_W)) u_marb (
      .req     (irq_req),
      .lvl_cfg (irq_lvl),
      .int_en  (int_en),
      .cur_ipl (ipl_q),
      .hit     (m_hit),
      .win_idx (m_idx),
      .win_lvl (m_lvl)
   );

   irqpr_tier_sel #(.N_SRC(N_SRC), .LVL_W(LVL_W), .ID_W(ID_W)) u_tier (
      .sp_vec   (sp_vec),
      .mask_hit (m_hit),
      .mask_idx (m_idx),
      .mask_lvl (m_lvl),
      .cur_ipl  (ipl_q),
      .valid    (w_valid),
      .win_id   (w_id),
      .win_lvl  (w_lvl)
   );

   assign fire   = sample_en && w_valid;
   assign pop_ok = ret_pulse && !fire && !stk_empty;

   irqpr_ctx_stack #(.DEPTH(STK_DEPTH), .W(CTX_W)) u_stk (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (fire),
      .pop   (pop_ok),
      .din   ({ipl_q, bank_q}),
      .dout  (stk_dout),
      .empty (stk_empty),
      .ovf   (stk_ovf)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ack_q  <= 1'b0;
         id_q   <= '0;
         lvl_q  <= '0;
         ipl_q  <= '0;
         bank_q <= '0;
      end else begin
         ack_q <= fire;
         if (fire) begin
            id_q   <= w_id;
            lvl_q  <= w_lvl;
            ipl_q  <= w_lvl;
            bank_q <= entry_bank;
         end else if (pop_ok) begin
            ipl_q  <= stk_dout[CTX_W-1:BANK_W];
            bank_q <= stk_dout[BANK_W-1:0];
         end
      end
   end

   assign ack      = ack_q;
   assign ack_id   = id_q;
   assign ack_lvl  = lvl_q;
   assign cur_ipl  = ipl_q;
   assign cur_bank = bank_q;
endmodule

// File: rtl/irqpr_chk.sv
module irqpr_chk #(
   parameter int N_SRC = 8,
   parameter int LVL_W = 3,
   parameter int ID_W  = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sample_en,
   input logic [N_SRC-1:0] irq_req,
   input logic             int_en,
   input logic             rst_req,
   input logic             swi_req,
   input logic             nmi_req,
   input logic             dbg_req,
   input logic             wdt_req,
   input logic             step_req,
   input logic             amatch_req,
   input logic             ack,
   input logic [ID_W-1:0]  ack_id,
   input logic [LVL_W-1:0] ack_lvl,
   input logic [LVL_W-1:0] cur_ipl,
   input logic             stk_ovf
);
   logic any_line;
   assign any_line = (|irq_req) || rst_req || swi_req || nmi_req || dbg_req ||
                     wdt_req || step_req || amatch_req;

   a_r1_ack_after_sample: assert property (@(posedge clk) disable iff (!rst_n)
      ack |-> $past(sample_en));

   a_r1_idle_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_en && !any_line) |=> !ack);

   a_r2_mask_above_ipl: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && (ack_id < ID_W'(N_SRC))) |-> ((ack_lvl > $past(cur_ipl)) && $past(int_en)));

   a_r4_reset_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_en && rst_req) |=> (ack && (ack_id == ID_W'(N_SRC))));

   a_r6_ipl_tracks_ack: assert property (@(posedge clk) disable iff (!rst_n)
      ack |-> (cur_ipl == ack_lvl));

   a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      stk_ovf |=> stk_ovf);
endmodule

bind irq_prio_resolver irqpr_chk #(.N_SRC(N_SRC), .LVL_W(LVL_W), .ID_W(ID_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .sample_en  (sample_en),
   .irq_req    (irq_req),
   .int_en     (int_en),
   .rst_req    (rst_req),
   .swi_req    (swi_req),
   .nmi_req    (nmi_req),
   .dbg_req    (dbg_req),
   .wdt_req    (wdt_req),
   .step_req   (step_req),
   .amatch_req (amatch_req),
   .ack        (ack),
   .ack_id     (ack_id),
   .ack_lvl    (ack_lvl),
   .cur_ipl    (cur_ipl),
   .stk_ovf    (stk_ovf)
);

// File: tb/irq_prio_resolver_test.sv
`timescale 1ns/100ps
module irq_prio_resolver_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sample_en = 1'b0;
   logic [7:0]  irq_req = '0;
   logic [23:0] irq_lvl = '0;
   logic        int_en = 1'b0;
   logic [6:0]  sp = '0;   // bit0 reset,1 swi,2 nmi,3 debug,4 wdt,5 step,6 addr
   logic        ret_pulse = 1'b0;
   logic [0:0]  entry_bank = '0;
   logic        ack;
   logic [3:0]  ack_id;
   logic [2:0]  ack_lvl;
   logic [2:0]  cur_ipl;
   logic [0:0]  cur_bank;
   logic        stk_ovf;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   irq_prio_resolver uut (
      .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .irq_req(irq_req),
      .irq_lvl(irq_lvl), .int_en(int_en), .rst_req(sp[0]), .swi_req(sp[1]),
      .nmi_req(sp[2]), .dbg_req(sp[3]), .wdt_req(sp[4]), .step_req(sp[5]),
      .amatch_req(sp[6]), .ret_pulse(ret_pulse), .entry_bank(entry_bank),
      .ack(ack), .ack_id(ack_id), .ack_lvl(ack_lvl), .cur_ipl(cur_ipl),
      .cur_bank(cur_bank), .stk_ovf(stk_ovf)
   );

   typedef struct packed {
      logic [7:0]  req;
      logic [23:0] lvl;
      logic        ie;
      logic [6:0]  sp;
      logic        e_ack;
      logic [3:0]  e_id;
      logic [2:0]  e_lvl;
   } vec_t;

   localparam int NV = 15;
   localparam vec_t TBL [NV] = '{
      '{8'h01, 24'o11111111, 1'b1, 7'h00, 1'b1, 4'd0,  3'd1},  // R2 single source
      '{8'h06, 24'o11111111, 1'b1, 7'h00, 1'b1, 4'd1,  3'd1},  // R3 tie, low index
      '{8'h82, 24'o51111131, 1'b1, 7'h00, 1'b1, 4'd7,  3'd5},  // R3 highest level
      '{8'h0C, 24'o00004400, 1'b1, 7'h00, 1'b1, 4'd2,  3'd4},  // R3 tie at 4
      '{8'hFF, 24'o00000000, 1'b1, 7'h00, 1'b0, 4'd0,  3'd0},  // R2 level 0 off
      '{8'hFF, 24'o77777777, 1'b0, 7'h00, 1'b0, 4'd0,  3'd0},  // R2 enable off
      '{8'hFF, 24'o77777777, 1'b0, 7'h04, 1'b1, 4'd10, 3'd7},  // R5 nmi ignores enable
      '{8'h00, 24'o00000000, 1'b0, 7'h7F, 1'b1, 4'd8,  3'd7},  // R4 reset first
      '{8'h00, 24'o00000000, 1'b0, 7'h7E, 1'b1, 4'd9,  3'd0},  // R4 R5 swi next
      '{8'h00, 24'o00000000, 1'b0, 7'h78, 1'b1, 4'd11, 3'd7},  // R4 debug
      '{8'h00, 24'o00000000, 1'b0, 7'h70, 1'b1, 4'd12, 3'd7},  // R4 watchdog
      '{8'h10, 24'o00010000, 1'b1, 7'h60, 1'b1, 4'd4,  3'd1},  // R4 maskable over step
      '{8'h10, 24'o00010000, 1'b0, 7'h60, 1'b1, 4'd13, 3'd7},  // R4 step
      '{8'h00, 24'o00000000, 1'b0, 7'h40, 1'b1, 4'd14, 3'd7},  // R4 address match
      '{8'h00, 24'o00000000, 1'b1, 7'h00, 1'b0, 4'd0,  3'd0}   // R1 nothing pending
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic apply_reset();
      @(negedge clk);
      rst_n = 1'b0; sample_en = 1'b0; irq_req = '0; irq_lvl = '0;
      int_en = 1'b0; sp = '0; ret_pulse = 1'b0; entry_bank = '0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic do_sample();
      sample_en = 1'b1;
      @(negedge clk);
      sample_en = 1'b0;
   endtask

   task automatic do_ret();
      ret_pulse = 1'b1;
      @(negedge clk);
      ret_pulse = 1'b0;
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 5);
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      // R9 reset state
      apply_reset();
      chk("R9 ack", ack, 0);
      chk("R9 cur_ipl", cur_ipl, 0);
      chk("R9 cur_bank", cur_bank, 0);
      chk("R9 stk_ovf", stk_ovf, 0);

      // Vector table, each row from reset
      for (int k = 0; k < NV; k++) begin
         apply_reset();
         irq_req = TBL[k].req; irq_lvl = TBL[k].lvl;
         int_en = TBL[k].ie;  sp = TBL[k].sp;
         do_sample();
         chk("R1 table ack", ack, TBL[k].e_ack);
         if (TBL[k].e_ack) begin
            chk("R3 R4 table id", ack_id, TBL[k].e_id);
            chk("R5 table lvl", ack_lvl, TBL[k].e_lvl);
            chk("R6 table ipl", cur_ipl, TBL[k].e_lvl);
         end
      end

      // R1: request held between samples waits
      apply_reset();
      irq_lvl = 24'o00211111; int_en = 1'b1; irq_req = 8'h01; entry_bank = 1'b1;
      for (int c = 0; c < 3; c++) begin
         @(negedge clk);
         chk("R1 no sample no ack", ack, 0);
      end
      do_sample();
      chk("R1 ack on sample", ack, 1);
      chk("R3 id", ack_id, 0);
      chk("R6 ipl", cur_ipl, 1);
      chk("R6 bank", cur_bank, 1);
      @(negedge clk);
      chk("R1 one-cycle pulse", ack, 0);

      // R2: equal level is not above ipl
      do_sample();
      chk("R2 equal level blocked", ack, 0);
      irq_req = 8'h21;
      do_sample();
      chk("R2 higher accepted", ack, 1);
      chk("R2 id", ack_id, 5);
      chk("R6 ipl 2", cur_ipl, 2);

      // R5: software request at ipl 2 keeps level
      irq_req = 8'h00; sp = 7'h02;
      do_sample();
      sp = '0;
      chk("R5 swi ack", ack, 1);
      chk("R5 swi id", ack_id, 9);
      chk("R5 swi lvl", ack_lvl, 2);
      chk("R5 swi ipl kept", cur_ipl, 2);

      // R7: pops restore in reverse order, empty pop ignored
      do_ret();
      chk("R7 pop1 ipl", cur_ipl, 2);
      chk("R7 pop1 bank", cur_bank, 1);
      do_ret();
      chk("R7 pop2 ipl", cur_ipl, 1);
      chk("R7 pop2 bank", cur_bank, 1);
      do_ret();
      chk("R7 pop3 ipl", cur_ipl, 0);
      chk("R7 pop3 bank", cur_bank, 0);
      do_ret();
      chk("R7 empty pop ipl", cur_ipl, 0);
      chk("R7 empty pop bank", cur_bank, 0);

      // R7: return coinciding with an acknowledging sample is ignored
      irq_req = 8'h21;
      sample_en = 1'b1; ret_pulse = 1'b1;
      @(negedge clk);
      sample_en = 1'b0; ret_pulse = 1'b0; irq_req = 8'h00;
      chk("R7 coincide ack", ack, 1);
      chk("R7 coincide ipl", cur_ipl, 2);
      do_ret();
      chk("R7 after coincide pop", cur_ipl, 0);
      do_ret();
      chk("R7 stack was one deep", cur_ipl, 0);

      // R8: overflow on fifth nested entry
      apply_reset();
      irq_lvl = 24'o00054321; int_en = 1'b1;
      for (int j = 0; j < 5; j++) begin
         irq_req = 8'(1 << j);
         do_sample();
         chk("R8 nest ipl", cur_ipl, j + 1);
         chk("R8 ovf flag", stk_ovf, (j == 4) ? 1 : 0);
      end
      irq_req = '0;
      repeat (3) @(negedge clk);
      chk("R8 ovf sticky", stk_ovf, 1);
      do_ret();
      chk("R8 dropped entry lost", cur_ipl, 3);
      chk("R8 ovf after pop", stk_ovf, 1);
      apply_reset();
      @(negedge clk);
      chk("R9 ovf cleared", stk_ovf, 0);

      finish_run();
   end
endmodule